// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns parallel audio samples into an I2S serial stream while acting as the clock provider for word select. A one-cycle bit-clock strobe advances it by one serial bit. Samples arrive through a valid/ready interface from an external sample FIFO. A 16-bit control word sets the sample width, the slot length, mono operation, stop, mute and channel reset.

The block drives the serial data line and word select. Word select toggles after a programmable number of bit clocks. Data goes out MSB first, one bit clock after each word-select edge.

A registered DMA request tells an external engine to refill the FIFO. It is raised when the FIFO fill level falls to a programmed depth or below.

Top module: `i2s_tx_channel`

## Requirements
- R1: The control word is decoded as follows:
  - bits 1:0 give the sample width: code 0 is 8 bits, code 1 is 16 bits, code 3 is 32 bits, and code 2 is treated as 16 bits;
  - bit 2 is mono;
  - bit 3 is stop;
  - bit 4 is channel reset;
  - bits 14:6 hold H, the slot length in bit clocks minus one;
  - bit 15 is mute.
- R2: Counting strobes from 1 after channel reset is released, wordSelect is low for strobes 1 to H+1, then toggles after every H+1 further strobes. Low marks the left slot.
- R3: Strobe 1 starts the left slot with an all-zero bit. Each slot's word is sent MSB first on the strobes that follow. Its LSB lands on the strobe that starts the next slot. Bit times beyond the sample width are zero.
- R4: Only the low W bits of sampleData are transmitted for width W. Higher bits are ignored.
- R5: In stereo mode, exactly one sample is taken per slot, left slot first. sampleReady is high only in strobe cycles that start a slot.
- R6: In mono mode, one sample is taken at each left slot. The same sample is sent again in the following right slot.
- R7: While stop is set:
  - no sample is taken;
  - serialData is 0;
  - wordSelect keeps its normal timing.
- R8: While mute is set, serialData is 0, while samples are still taken and wordSelect keeps running.
- R9: While channel reset is set:
  - the bit counter is cleared;
  - wordSelect is low;
  - any partly sent or held sample is discarded;
  - no sample is taken.
  After release, sequencing restarts at strobe 1.
- R10: If sampleValid is low when a slot starts, that slot carries an all-zero word.
- R11: One clock after the inputs, dmaReq equals txDmaEn AND (fifoLevel <= dmaDepth). The control word has no effect on it.
- R12: sampleReady is low in every cycle without a bit-clock strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitStrobe | input | 1 | One-cycle pulse per serial bit clock |
| ctrlWord | input | 16 | Control word (see R1) |
| txDmaEn | input | 1 | Enables the DMA request |
| dmaDepth | input | DEPTH_W (4) | DMA request threshold |
| fifoLevel | input | LEVEL_W (5) | Current fill level of the sample FIFO |
| sampleData | input | SAMPLE_W (32) | Sample at the head of the FIFO |
| sampleValid | input | 1 | FIFO holds a sample |
| sampleReady | output | 1 | Sample is taken in this cycle when valid |
| serialData | output | 1 | Serial audio data |
| wordSelect | output | 1 | Word select, low for the left slot |
| dmaReq | output | 1 | FIFO refill request |

## Verification
The assertions assume the following about the inputs:
- bitStrobe is a single-cycle pulse;
- the control word changes only between strobes;
- a channel reset is applied through the control word before each new configuration is used.

Under these assumptions, word select moves only on a strobe, and never in the middle of a slot. The stimulus keeps within them: strobes are spaced by at least one idle clock, and every scenario begins by holding the reset bit for two clocks with the new settings. The FIFO model only presents data that the bench has preloaded, and it advances exactly on a valid/ready handshake.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
  localparam int CTRL_W = 16;
  localparam int HALF_W = 9;

  typedef enum logic [1:0] {
    WID8   = 2'd0,
    WID16  = 2'd1,
    WIDRSV = 2'd2,
    WID32  = 2'd3
  } widthCode_e;

  // Field placement follows the control word decode (R1).
  typedef struct packed {
    logic              mute;
    logic [HALF_W-1:0] halfM1;
    logic              spare;
    logic              chanRst;
    logic              stop;
    logic              mono;
    widthCode_e        width;
  } txCtrl_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic shift;
    logic load;
    logic slotRight;
    logic pop;
    logic flush;
  } txStrobe_t;
endpackage

// File: rtl/i2stx_ctrl.sv
module i2stx_ctrl
  import i2stx_pkg::*;
#(
  parameter int CNT_W = HALF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStrobe,
  input  logic [CNT_W-1:0] halfM1,
  input  logic             chanRst,
  input  logic             stop,
  input  logic             mono,
  output txStrobe_t        stb,
  output logic             wsOut,
  output logic             sampleReady
);
  logic [CNT_W-1:0] bitCnt;
  logic             wsReg;
  logic             armed;
  logic             wrap;

  always_comb begin
    wrap          = (bitCnt >= halfM1);
    stb.flush     = chanRst;
    stb.shift     = bitStrobe & ~chanRst;
    stb.load      = stb.shift & (armed | wrap);
    stb.slotRight = armed ? 1'b0 : ~wsReg;
    stb.pop       = stb.load & ~stop & (~mono | ~stb.slotRight);
    sampleReady   = stb.pop;
    wsOut         = wsReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      wsReg  <= 1'b0;
      armed  <= 1'b1;
    end else if (chanRst) begin
      bitCnt <= '0;
      wsReg  <= 1'b0;
      armed  <= 1'b1;
    end else if (bitStrobe) begin
      if (armed) begin
        armed <= 1'b0;
      end else if (wrap) begin
        bitCnt <= '0;
        wsReg  <= ~wsReg;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R9: channel reset leaves the counter and word select cleared.
  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    chanRst |=> (!wsReg && bitCnt == '0));

  // R2: without a strobe, word select cannot move.
  assert_ws_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!bitStrobe && !chanRst) |=> $stable(wsReg));

  // R2: mid-slot strobes leave word select alone.
  assert_ws_midslot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !chanRst && !armed && bitCnt < halfM1) |=> $stable(wsReg));
endmodule

// File: rtl/i2stx_datapath.sv
module i2stx_datapath
  import i2stx_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           stb,
  input  widthCode_e          width,
  input  logic                mono,
  input  logic                stop,
  input  logic                mute,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  output logic                serialData
);
  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] shReg;
  logic [SAMPLE_W-1:0] heldWord;
  logic [SAMPLE_W-1:0] aligned;
  logic [SAMPLE_W-1:0] nextWord;
  logic                sdReg;
  int                  wordBits;

  always_comb begin
    unique case (width)
      WID8:    wordBits = 8;
      WID32:   wordBits = 32;
      default: wordBits = 16;
    endcase
    aligned = sampleData << (SAMPLE_W - wordBits);
    if (stb.pop) begin
      nextWord = sampleValid ? aligned : '0;
    end else if (mono && stb.slotRight && !stop) begin
      nextWord = heldWord;
    end else begin
      nextWord = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      heldWord <= '0;
      sdReg    <= 1'b0;
    end else if (stb.flush) begin
      shReg    <= '0;
      heldWord <= '0;
      sdReg    <= 1'b0;
    end else if (stb.shift) begin
      sdReg <= shReg[MSB];
      if (stb.load) begin
        shReg <= nextWord;
        if (!stb.slotRight) heldWord <= nextWord;
      end else begin
        shReg <= {shReg[MSB-1:0], 1'b0};
      end
    end
  end

  assign serialData = sdReg & ~(stop | mute);

  // R7: a slot started under stop carries only zeros.
  assert_stop_zero_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stop) |=> (shReg == '0));
endmodule

// File: rtl/i2stx_dmareq.sv
module i2stx_dmareq #(
  parameter int LEVEL_W = 5,
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txDmaEn,
  input  logic [DEPTH_W-1:0] dmaDepth,
  input  logic [LEVEL_W-1:0] fifoLevel,
  output logic               dmaReq
);
  localparam int CMP_W = (LEVEL_W > DEPTH_W) ? LEVEL_W : DEPTH_W;

  logic [CMP_W-1:0] levelX;
  logic [CMP_W-1:0] depthX;

  assign levelX = CMP_W'(fifoLevel);
  assign depthX = CMP_W'(dmaDepth);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dmaReq <= 1'b0;
    else       dmaReq <= txDmaEn && (levelX <= depthX);
  end

  // R11: a disabled request stays low on the next clock.
  assert_dma_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !txDmaEn |=> !dmaReq);
endmodule

// File: rtl/i2s_tx_channel.sv
module i2s_tx_channel
  import i2stx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int LEVEL_W  = 5,
  parameter int DEPTH_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitStrobe,
  input  logic [CTRL_W-1:0]   ctrlWord,
  input  logic                txDmaEn,
  input  logic [DEPTH_W-1:0]  dmaDepth,
  input  logic [LEVEL_W-1:0]  fifoLevel,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  output logic                sampleReady,
  output logic                serialData,
  output logic                wordSelect,
  output logic                dmaReq
);
  txCtrl_t   cfg;
  txStrobe_t stb;
  logic      unusedSpare;

  assign cfg         = txCtrl_t'(ctrlWord);
  assign unusedSpare = cfg.spare;

  i2stx_ctrl #(.CNT_W(HALF_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .bitStrobe   (bitStrobe),
    .halfM1      (cfg.halfM1),
    .chanRst     (cfg.chanRst),
    .stop        (cfg.stop),
    .mono        (cfg.mono),
    .stb         (stb),
    .wsOut       (wordSelect),
    .sampleReady (sampleReady)
  );

  i2stx_datapath #(.SAMPLE_W(SAMPLE_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .width       (cfg.width),
    .mono        (cfg.mono),
    .stop        (cfg.stop),
    .mute        (cfg.mute),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .serialData  (serialData)
  );

  i2stx_dmareq #(.LEVEL_W(LEVEL_W), .DEPTH_W(DEPTH_W)) uDma (
    .clk       (clk),
    .rstN      (rstN),
    .txDmaEn   (txDmaEn),
    .dmaDepth  (dmaDepth),
    .fifoLevel (fifoLevel),
    .dmaReq    (dmaReq)
  );

  // R7: no sample is taken while stopped.
  assert_stop_no_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfg.stop |-> !sampleReady);

  // R12: the FIFO is only offered a handshake in strobe cycles.
  assert_ready_needs_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> bitStrobe);
endmodule

// File: tb/sim_i2s_tx_channel.sv
module sim_i2s_tx_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitStrobe = 1'b0;
  logic [15:0] ctrlWord = 16'h0010;
  logic        txDmaEn = 1'b0;
  logic [3:0]  dmaDepth = 4'd0;
  logic [4:0]  fifoLevel = 5'd0;
  logic [31:0] sampleData;
  logic        sampleValid;
  logic        sampleReady, serialData, wordSelect, dmaReq;

  int checks = 0;
  int errors = 0;
  logic [31:0] fifoMem [0:63];
  int wrPtr = 0;
  int rdPtr = 0;

  always #5 clk = ~clk;

  assign sampleValid = (rdPtr < wrPtr);
  assign sampleData  = sampleValid ? fifoMem[6'(rdPtr)] : 32'h0;

  i2s_tx_channel u0 (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .ctrlWord(ctrlWord),
    .txDmaEn(txDmaEn), .dmaDepth(dmaDepth), .fifoLevel(fifoLevel),
    .sampleData(sampleData), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .serialData(serialData), .wordSelect(wordSelect), .dmaReq(dmaReq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCtrl(input logic [1:0] wc, input bit mono, input bit stop,
                                         input bit mute, input int halfM1);
    return {mute, 9'(halfM1), 1'b0, 1'b0, stop, mono, wc};
  endfunction

  task automatic fill(input int n, input logic [31:0] seed);
    rdPtr = 0;
    wrPtr = 0;
    for (int i = 0; i < n; i++) begin
      fifoMem[i] = (32'hA5C3_0F1E ^ (32'(i) * 32'h9E37_79B9)) + seed;
      wrPtr++;
    end
  endtask

  task automatic restart(input logic [15:0] c);
    @(negedge clk);
    ctrlWord = c | 16'h0010;
    @(negedge clk);
    @(negedge clk);
    ctrlWord = c;
  endtask

  task automatic doStrobe(output logic sd, output logic ws, output bit popped, output logic rdy);
    @(negedge clk);
    bitStrobe = 1'b1;
    #1;
    rdy = sampleReady;
    popped = sampleReady && sampleValid;
    @(negedge clk);
    bitStrobe = 1'b0;
    if (popped) rdPtr++;
    sd = serialData;
    ws = wordSelect;
  endtask

  function automatic logic [1:0] model(input int n, input int p, input int w, input bit mono,
                                       input int base, input bit silent);
    logic wsE, sdE;
    int k, slot, pos, idx;
    wsE = 1'(((n - 1) / p) % 2);
    sdE = 1'b0;
    if (n >= 2 && !silent) begin
      k = n - 2;
      slot = k / p;
      pos = k % p;
      idx = mono ? slot / 2 : slot;
      if (pos < w && base + idx < wrPtr) sdE = fifoMem[6'(base + idx)][w - 1 - pos];
    end
    return {wsE, sdE};
  endfunction

  // Runs n strobes from a fresh start and compares each one with the model.
  task automatic runSeq(input string req, input int nStr, input int p, input int w, input bit mono,
                        input bit silent, input bit noPop);
    int base, loads, want, avail;
    logic sd, ws, rdy;
    logic [1:0] e;
    bit popped;
    base = rdPtr;
    for (int n = 1; n <= nStr; n++) begin
      doStrobe(sd, ws, popped, rdy);
      e = model(n, p, w, mono, base, silent);
      check({ws, sd} == e, req, 64'({ws, sd}), 64'(e));
    end
    loads = 1 + (nStr - 1) / p;
    want  = noPop ? 0 : (mono ? (loads + 1) / 2 : loads);
    avail = wrPtr - base;
    if (want > avail) want = avail;
    check(rdPtr - base == want, {req, " pops"}, 64'(rdPtr - base), 64'(want));
  endtask

  task automatic testResetState();
    check(wordSelect == 1'b0 && serialData == 1'b0 && sampleReady == 1'b0,
          "R9 reset state", 64'({wordSelect, serialData, sampleReady}), 64'(0));
    check(dmaReq == 1'b0, "R11 reset dmaReq", 64'(dmaReq), 64'(0));
  endtask

  task automatic testStereo8();
    fill(6, 32'h11);
    restart(mkCtrl(2'd0, 0, 0, 0, 7));
    runSeq("R3 R4 R5 stereo 8-bit", 33, 8, 8, 0, 0, 0);
    @(negedge clk);
    #1;
    check(sampleReady == 1'b0 && sampleValid, "R12 idle ready", 64'(sampleReady), 64'(0));
  endtask

  task automatic testWidths();
    fill(6, 32'h2222);
    restart(mkCtrl(2'd1, 0, 0, 0, 15));
    runSeq("R2 R4 stereo 16-bit", 40, 16, 16, 0, 0, 0);
    fill(6, 32'h3333);
    restart(mkCtrl(2'd3, 0, 0, 0, 31));
    runSeq("R4 stereo 32-bit", 70, 32, 32, 0, 0, 0);
    fill(6, 32'h4444);
    restart(mkCtrl(2'd0, 0, 0, 0, 11));
    runSeq("R3 8-bit in 12-bit slot", 30, 12, 8, 0, 0, 0);
    fill(6, 32'h5555);
    restart(mkCtrl(2'd2, 0, 0, 0, 15));
    runSeq("R1 code 2 as 16-bit", 36, 16, 16, 0, 0, 0);
  endtask

  task automatic testMono();
    fill(6, 32'h66);
    restart(mkCtrl(2'd0, 1, 0, 0, 7));
    runSeq("R6 mono", 40, 8, 8, 1, 0, 0);
  endtask

  task automatic testUnderrun();
    fill(1, 32'h77);
    restart(mkCtrl(2'd0, 0, 0, 0, 7));
    runSeq("R10 underrun", 33, 8, 8, 0, 0, 0);
  endtask

  task automatic testStopMute();
    fill(4, 32'h88);
    restart(mkCtrl(2'd0, 0, 1, 0, 7));
    runSeq("R7 stop", 20, 8, 8, 0, 1, 1);
    fill(4, 32'h99);
    restart(mkCtrl(2'd0, 0, 0, 1, 7));
    runSeq("R8 mute", 20, 8, 8, 0, 1, 0);
  endtask

  task automatic testMidReset();
    logic sd, ws, rdy;
    bit popped;
    fill(8, 32'hAA);
    restart(mkCtrl(2'd0, 0, 0, 0, 7));
    runSeq("R9 before reset", 10, 8, 8, 0, 0, 0);
    ctrlWord = mkCtrl(2'd0, 0, 0, 0, 7) | 16'h0010;
    @(negedge clk);
    @(negedge clk);
    check(wordSelect == 1'b0 && serialData == 1'b0, "R9 reset clears",
          64'({wordSelect, serialData}), 64'(0));
    doStrobe(sd, ws, popped, rdy);
    check(!rdy && !ws && !sd, "R9 strobe during reset", 64'({rdy, ws, sd}), 64'(0));
    ctrlWord = mkCtrl(2'd0, 0, 0, 0, 7);
    runSeq("R9 restart after reset", 17, 8, 8, 0, 0, 0);
  endtask

  task automatic dmaStep(input bit en, input logic [3:0] dep, input logic [4:0] lvl,
                         input bit exp, input string req);
    @(negedge clk);
    txDmaEn = en;
    dmaDepth = dep;
    fifoLevel = lvl;
    @(negedge clk);
    check(dmaReq == exp, req, 64'(dmaReq), 64'(exp));
  endtask

  task automatic testDma();
    dmaStep(1, 4'd4, 5'd4, 1, "R11 level equals depth");
    dmaStep(1, 4'd4, 5'd5, 0, "R11 level above depth");
    dmaStep(1, 4'd4, 5'd0, 1, "R11 empty fifo");
    dmaStep(1, 4'd0, 5'd1, 0, "R11 depth 0 level 1");
    dmaStep(0, 4'd4, 5'd0, 0, "R11 disabled");
    ctrlWord = 16'h0018;
    dmaStep(1, 4'd4, 5'd2, 1, "R11 control has no effect");
    dmaStep(1, 4'd15, 5'd16, 0, "R11 level wider than depth");
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testStereo8();
    testWidths();
    testMono();
    testUnderrun();
    testStopMute();
    testMidReset();
    testDma();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule